// File: doc/BRIEF.md
# Full-Speed Frame Interval Timer

This block keeps the frame timing of a full-speed USB host. Software programs a frame interval register that holds the reload count, a largest-packet field and a toggle bit. The block counts bit times down from that reload value. When the count reaches zero, the next bit-time tick starts a new frame. At that tick the block reloads the count, copies the toggle bit, advances a 16-bit frame number and pulses a start-of-frame event.

A second register holds a periodic threshold. Partway through each frame, once the remaining count falls to that threshold, the block raises a priority flag for periodic traffic. The flag drops again at the next frame start. A frame-number rollover event fires whenever the top bit of the frame number changes. Counting advances only in cycles where both the run input and the bit-time tick are high.

Top module: `frame_timer`

## Requirements
- R1: After reset, `ivl_rdata` reads the reset interval with its count field set to RESET_FI (11999), its largest-packet field set to RESET_MPS and its toggle bit at 0. `remain_rdata`, `fnum`, `sof_pulse`, `fno_pulse` and `periodic_pri` are all zero.
- R2: A write to the interval register stores the reload count in bits 13:0, the largest-packet size in bits 30:16 and the toggle in bit 31. `ivl_rdata` returns the written word from the next cycle, with bits 15:14 reading as zero.
- R3: When `run` and `bit_tick` are both high and the remaining count is non-zero, the remaining count drops by exactly one at that clock edge.
- R4: In a cycle where `run` or `bit_tick` is low, the remaining count, toggle, frame number and priority flag keep their values, and neither event pulse is raised.
- R5: When `run` and `bit_tick` are both high and the remaining count is zero, the edge reloads the count from bits 13:0 of the interval register and copies its bit 31 into bit 31 of `remain_rdata`. The same edge advances `fnum` by one, and `sof_pulse` is high for the single cycle that follows.
- R6: A write to the interval register during a frame leaves the current count untouched. The new value is used at the next reload. A write in the same cycle as a reload has the reload use the value held before that write.
- R7: `remain_rdata` carries the remaining count in bits 13:0 and the copied toggle in bit 31, with every other bit zero.
- R8: `fnum` wraps from 0xFFFF to 0x0000. `fno_pulse` is high for one cycle after any frame start that changes bit 15 of `fnum`, which happens at 0x7FFF to 0x8000 and at 0xFFFF to 0x0000.
- R9: After a counting tick that does not reload, `periodic_pri` is high exactly when the new remaining count is at or below the periodic threshold in force before that edge. After a reload tick it is low.
- R10: A write to the periodic threshold stores the 14-bit value and uses it from the next counting tick on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable |
| bit_tick | input | 1 | One-cycle pulse per full-speed bit time |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wdata | input | 32 | Interval register write data |
| pstart_wr | input | 1 | Write strobe for the periodic threshold |
| pstart_wdata | input | 14 | Periodic threshold write data |
| ivl_rdata | output | 32 | Interval register read value |
| remain_rdata | output | 32 | Remaining count and copied toggle |
| fnum | output | 16 | Current frame number |
| sof_pulse | output | 1 | Start-of-frame event |
| fno_pulse | output | 1 | Frame-number top-bit change event |
| periodic_pri | output | 1 | Periodic traffic has priority |

## Verification
The hardest case to reach from the ports is a change of the frame number's top bit. That needs tens of thousands of frames, and at the usual interval this would take hundreds of millions of ticks. The bench programs a reload count of zero, which makes every tick a frame boundary. It then ticks on every cycle for a little over 65536 cycles, so both the 0x7FFF to 0x8000 step and the 0xFFFF wrap happen. Before that run, it writes the interval in the same cycle as a reload. This shows that the reload takes the old value while the readback shows the new one.

// File: rtl/ft_pkg.sv
package ft_pkg;
   localparam int FT_WORD_W  = 32;
   localparam int FT_TOG_BIT = 31;
   localparam int FT_MPS_LSB = 16;

   function automatic logic [FT_WORD_W-1:0] ft_field_mask(input int lsb, input int width);
      logic [FT_WORD_W-1:0] m;
      m = '0;
      for (int i = 0; i < FT_WORD_W; i++) begin
         if (i >= lsb && i < lsb + width) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/ft_cfg_regs.sv
module ft_cfg_regs
   import ft_pkg::*;
#(
   parameter int FI_W      = 14,
   parameter int MPS_W     = 15,
   parameter int RESET_FI  = 11999,
   parameter int RESET_MPS = 0,
   parameter int RESET_PS  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ivl_wr,
   input  logic [FT_WORD_W-1:0] ivl_wdata,
   input  logic                 ps_wr,
   input  logic [FI_W-1:0]      ps_wdata,
   output logic [FT_WORD_W-1:0] ivl_q,
   output logic [FI_W-1:0]      ps_q
);
   localparam logic [FT_WORD_W-1:0] IVL_MASK =
      ft_field_mask(0, FI_W) | ft_field_mask(FT_MPS_LSB, MPS_W) | ft_field_mask(FT_TOG_BIT, 1);
   localparam logic [FT_WORD_W-1:0] IVL_RESET =
      (FT_WORD_W'(RESET_FI) & ft_field_mask(0, FI_W)) |
      ((FT_WORD_W'(RESET_MPS) << FT_MPS_LSB) & ft_field_mask(FT_MPS_LSB, MPS_W));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ivl_q <= IVL_RESET;
         ps_q  <= FI_W'(RESET_PS);
      end else begin
         if (ivl_wr) ivl_q <= ivl_wdata & IVL_MASK;
         if (ps_wr)  ps_q  <= ps_wdata;
      end
   end

   AST_IVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ivl_wr |=> $stable(ivl_q)); // R6
   AST_PS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ps_wr |=> ps_q == $past(ps_wdata)); // R10
endmodule

// File: rtl/ft_bit_counter.sv
module ft_bit_counter #(
   parameter int FI_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [FI_W-1:0] reload_val,
   input  logic            reload_tog,
   output logic [FI_W-1:0] rem_q,
   output logic            tog_q,
   output logic [FI_W-1:0] rem_next,
   output logic            wrap
);
   assign wrap = step && (rem_q == '0);

   always_comb begin
      if (wrap)      rem_next = reload_val;
      else if (step) rem_next = rem_q - 1'b1;
      else           rem_next = rem_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         tog_q <= 1'b0;
      end else begin
         rem_q <= rem_next;
         if (wrap) tog_q <= reload_tog;
      end
   end

   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (step && rem_q != '0) |=> rem_q == $past(rem_q) - 1'b1); // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(rem_q) && $stable(tog_q))); // R4
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (rem_q == $past(reload_val) && tog_q == $past(reload_tog))); // R5
endmodule

// File: rtl/ft_frame_count.sv
module ft_frame_count #(
   parameter int FN_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wrap,
   output logic [FN_W-1:0] fnum_q,
   output logic            sof_q,
   output logic            fno_q
);
   localparam int MSB = FN_W - 1;
   logic [FN_W-1:0] fnum_inc;
   assign fnum_inc = fnum_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fnum_q <= '0;
         sof_q  <= 1'b0;
         fno_q  <= 1'b0;
      end else begin
         sof_q <= wrap;
         fno_q <= wrap && (fnum_inc[MSB] != fnum_q[MSB]);
         if (wrap) fnum_q <= fnum_inc;
      end
   end

   AST_SOF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      sof_q |-> fnum_q == $past(fnum_q) + 1'b1); // R5
   AST_FNUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(fnum_q) && !sof_q && !fno_q)); // R4
   AST_FNO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      fno_q |-> fnum_q[MSB] != $past(fnum_q[MSB])); // R8
endmodule

// File: rtl/ft_periodic_flag.sv
module ft_periodic_flag #(
   parameter int FI_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            wrap,
   input  logic [FI_W-1:0] rem_next,
   input  logic [FI_W-1:0] ps_q,
   output logic            pri_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     pri_q <= 1'b0;
      else if (wrap)  pri_q <= 1'b0;
      else if (step)  pri_q <= (rem_next <= ps_q);
   end

   AST_PRI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !pri_q); // R9
   AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pri_q)); // R4
endmodule

// File: rtl/frame_timer.sv
module frame_timer
   import ft_pkg::*;
#(
   parameter int FI_W      = 14,
   parameter int MPS_W     = 15,
   parameter int FN_W      = 16,
   parameter int RESET_FI  = 11999,
   parameter int RESET_MPS = 0,
   parameter int RESET_PS  = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        bit_tick,
   input  logic        ivl_wr,
   input  logic [31:0] ivl_wdata,
   input  logic        pstart_wr,
   input  logic [13:0] pstart_wdata,
   output logic [31:0] ivl_rdata,
   output logic [31:0] remain_rdata,
   output logic [15:0] fnum,
   output logic        sof_pulse,
   output logic        fno_pulse,
   output logic        periodic_pri
);
   generate
      if (FI_W != 14) begin : g_bad_fi
         $error("frame_timer: count field must be 14 bits wide");
      end
      if (MPS_W < 1 || FT_MPS_LSB + MPS_W > FT_TOG_BIT) begin : g_bad_mps
         $error("frame_timer: packet field overlaps the toggle bit");
      end
      if (FN_W != 16) begin : g_bad_fn
         $error("frame_timer: frame number must be 16 bits wide");
      end
      if (RESET_FI < 0 || RESET_FI >= (1 << FI_W)) begin : g_bad_rfi
         $error("frame_timer: reset interval does not fit the count field");
      end
   endgenerate

   logic                 step;
   logic [FT_WORD_W-1:0] ivl_q;
   logic [FI_W-1:0]      ps_q;
   logic [FI_W-1:0]      rem_q;
   logic [FI_W-1:0]      rem_next;
   logic                 tog_q;
   logic                 wrap;

   assign step = run && bit_tick;

   ft_cfg_regs #(
      .FI_W(FI_W), .MPS_W(MPS_W), .RESET_FI(RESET_FI),
      .RESET_MPS(RESET_MPS), .RESET_PS(RESET_PS)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
      .ps_wr(pstart_wr), .ps_wdata(pstart_wdata),
      .ivl_q(ivl_q), .ps_q(ps_q)
   );

   ft_bit_counter #(.FI_W(FI_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step),
      .reload_val(ivl_q[FI_W-1:0]), .reload_tog(ivl_q[FT_TOG_BIT]),
      .rem_q(rem_q), .tog_q(tog_q), .rem_next(rem_next), .wrap(wrap)
   );

   ft_frame_count #(.FN_W(FN_W)) u_fn (
      .clk(clk), .rst_n(rst_n), .wrap(wrap),
      .fnum_q(fnum), .sof_q(sof_pulse), .fno_q(fno_pulse)
   );

   ft_periodic_flag #(.FI_W(FI_W)) u_pri (
      .clk(clk), .rst_n(rst_n), .step(step), .wrap(wrap),
      .rem_next(rem_next), .ps_q(ps_q), .pri_q(periodic_pri)
   );

   assign ivl_rdata = ivl_q;

   always_comb begin
      remain_rdata                = '0;
      remain_rdata[FI_W-1:0]      = rem_q;
      remain_rdata[FT_TOG_BIT]    = tog_q;
   end

   AST_SOF_PRI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |-> !periodic_pri); // R9
   AST_REMAIN_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
      remain_rdata[30:FI_W] == '0); // R7
   AST_PRI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wrap) |=> periodic_pri == (remain_rdata[FI_W-1:0] <= $past(ps_q))); // R9
endmodule

// File: tb/frame_timer_tb.sv
`timescale 1ns/1ps
module frame_timer_tb;
   typedef struct packed {
      logic [31:0] ivl;
      logic [31:0] rem;
      logic [15:0] fn;
      logic        sof;
      logic        fno;
      logic        pri;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0, bit_tick = 1'b0, ivl_wr = 1'b0, pstart_wr = 1'b0;
   logic [31:0] ivl_wdata = '0;
   logic [13:0] pstart_wdata = '0;
   logic [31:0] ivl_rdata, remain_rdata;
   logic [15:0] fnum;
   logic        sof_pulse, fno_pulse, periodic_pri;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   exp_t  expq[$];
   string tagq[$];

   logic [31:0] m_ivl = 32'd11999;
   logic [13:0] m_ps = '0, m_rem = '0;
   logic        m_tog = 1'b0, m_pri = 1'b0;
   logic [15:0] m_fn = '0;

   always #2.5 clk = ~clk;

   frame_timer u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
      .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
      .pstart_wr(pstart_wr), .pstart_wdata(pstart_wdata),
      .ivl_rdata(ivl_rdata), .remain_rdata(remain_rdata), .fnum(fnum),
      .sof_pulse(sof_pulse), .fno_pulse(fno_pulse), .periodic_pri(periodic_pri)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic r, input logic tk, input logic iw, input logic [31:0] id,
                       input logic pw, input logic [13:0] pd, input string tag);
      exp_t e;
      logic [15:0] nfn;
      @(negedge clk);
      run = r; bit_tick = tk; ivl_wr = iw; ivl_wdata = id; pstart_wr = pw; pstart_wdata = pd;
      e.sof = 1'b0; e.fno = 1'b0;
      if (r && tk) begin
         if (m_rem == 0) begin
            m_rem = m_ivl[13:0]; m_tog = m_ivl[31];
            nfn = m_fn + 16'd1;
            e.fno = (nfn[15] != m_fn[15]);
            m_fn = nfn; e.sof = 1'b1; m_pri = 1'b0;
         end else begin
            m_rem = m_rem - 14'd1;
            m_pri = (m_rem <= m_ps);
         end
      end
      if (iw) m_ivl = id & 32'hFFFF_3FFF;
      if (pw) m_ps = pd;
      e.ivl = m_ivl;
      e.rem = {m_tog, 17'd0, m_rem};
      e.fn = m_fn; e.pri = m_pri;
      expq.push_back(e);
      tagq.push_back(tag);
   endtask

   // monitor: compares each queued expectation just after the edge it belongs to
   always begin
      exp_t  e;
      string t;
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
         e = expq.pop_front();
         t = tagq.pop_front();
         chk({t, "/R2"}, "ivl_rdata", ivl_rdata, e.ivl);
         chk({t, "/R7"}, "remain_rdata", remain_rdata, e.rem);
         chk(t, "fnum", {16'd0, fnum}, {16'd0, e.fn});
         chk(t, "sof_pulse", {31'd0, sof_pulse}, {31'd0, e.sof});
         chk({t, "/R8"}, "fno_pulse", {31'd0, fno_pulse}, {31'd0, e.fno});
         chk({t, "/R9"}, "periodic_pri", {31'd0, periodic_pri}, {31'd0, e.pri});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "ivl_rdata", ivl_rdata, 32'd11999);
      chk("R1", "remain_rdata", remain_rdata, 32'd0);
      chk("R1", "fnum", {16'd0, fnum}, 32'd0);
      chk("R1", "events", {29'd0, sof_pulse, fno_pulse, periodic_pri}, 32'd0);

      step(0, 1, 1, 32'h8123_0005, 0, 14'd0, "R2_R4");   // write while halted
      step(0, 0, 0, 32'd0, 1, 14'd2, "R10");
      step(1, 0, 0, 32'd0, 0, 14'd0, "R4");             // run without tick
      step(1, 1, 0, 32'd0, 0, 14'd0, "R5");             // reload 5, toggle 1
      step(1, 1, 0, 32'd0, 0, 14'd0, "R3");             // 4
      step(1, 1, 0, 32'd0, 0, 14'd0, "R3");             // 3
      step(1, 1, 0, 32'd0, 0, 14'd0, "R9");             // 2, priority on
      step(1, 0, 0, 32'd0, 0, 14'd0, "R4");
      step(0, 1, 0, 32'd0, 0, 14'd0, "R4");
      step(1, 1, 0, 32'd0, 0, 14'd0, "R3");             // 1
      step(1, 1, 1, 32'h0000_0003, 0, 14'd0, "R6");     // 0, write mid-frame
      step(1, 1, 1, 32'h7FFF_C007, 0, 14'd0, "R6");     // reload 3 with toggle 0
      step(1, 1, 0, 32'd0, 0, 14'd0, "R9");             // 2 <= 2
      step(1, 1, 0, 32'd0, 0, 14'd0, "R3");
      step(1, 1, 0, 32'd0, 0, 14'd0, "R3");
      step(1, 1, 1, 32'h8000_0000, 1, 14'd0, "R5");     // reload 7
      for (int i = 0; i < 7; i++) step(1, 1, 0, 32'd0, 0, 14'd0, "R3");
      for (int i = 0; i < 65545; i++) step(1, 1, 0, 32'd0, 0, 14'd0, "R8");
      step(0, 0, 0, 32'd0, 0, 14'd0, "R4");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule